// File: doc/BRIEF.md
# Power-on configuration initialization sequencer

This block carries a programmable logic device from the moment its supply is declared good up to the point where configuration may begin. While a power-good input is low, the sequencer sits idle with every user output released. When power-good rises, it samples three mode-select pins once, decodes them into a configuration mode and starts an initialization time-out. The time-out advances only on a free-running slow tick, roughly 1 MHz, that comes from outside the block.

While the time-out runs, user I/O drivers stay in high impedance with weak pull-ups on, and power-down requests are blocked. The configuration clock pin is set to drive or to receive according to the decoded mode. Master modes wait four times the base time-out, so that any slave devices they feed finish their own initialization first. At the end the block raises a ready flag. A reserved mode code never reaches ready and raises an error flag instead. All pins are plain control and status levels, so no handshake is involved.

Top module: `poweron_init_seq`

## Requirements
- R1: The select code `cfg_sel` is read as the 3-bit value {cfg_sel[2],cfg_sel[1],cfg_sel[0]}. It decodes to `cfg_mode` as follows: 3'b000 to 0 (master serial), 3'b001 to 1 (master byte-wide, address up), 3'b011 to 2 (master byte-wide, address down), 3'b101 to 3 (peripheral byte-wide) and 3'b111 to 4 (slave serial). The value 7 means no valid mode (idle or reserved).
- R2: In peripheral and slave modes, `cfg_ready` rises at the clock edge that samples the BASE_TICKS-th `tick` pulse counted since power-good rose, and no earlier.
- R3: In the three master modes, `cfg_ready` rises at the edge that samples tick number 4*BASE_TICKS, and no earlier.
- R4: `io_hiz` is 1 in every state except ready. `io_pullup_en` is 1 while initialization or the mode error holds, and 0 when idle or ready.
- R5: `pwrdn_inhibit` is 1 while initialization or the mode error holds. `pwrdn_ok` equals `pwrdn_req` masked by that inhibit, so a request made during the time-out is ignored.
- R6: `cfg_clk_drive` is 1 (clock pin is an output) in the three master modes and in peripheral mode. It is 0 in slave mode, when idle and when the mode is invalid.
- R7: The mode pins are captured only at the edge where power-good is first seen high. Pin changes after that alter neither `cfg_mode`, `cfg_clk_drive` nor the time-out length.
- R8: The reserved codes 3'b010, 3'b100 and 3'b110 raise `mode_err` one cycle after capture. `cfg_ready` then stays 0 however many ticks arrive, and the I/O stays high impedance with pull-ups on.
- R9: A clock edge that samples `pwr_good` low returns the block to idle: `cfg_ready`=0, `mode_err`=0, `cfg_mode`=7, `cfg_clk_drive`=0, `io_pullup_en`=0 and `io_hiz`=1.
- R10: Ticks that arrive while idle do not count toward the time-out. Once `cfg_ready` or `mode_err` is set, it holds through further ticks until power-good falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply good; low acts as a synchronous reset to idle |
| tick | input | 1 | One-cycle pulse from the free-running slow timer |
| cfg_sel | input | 3 | Mode-select pins |
| pwrdn_req | input | 1 | Power-down request |
| io_hiz | output | 1 | Hold user output drivers in high impedance |
| io_pullup_en | output | 1 | Weak pull-up enable for user pins |
| pwrdn_inhibit | output | 1 | Power-down blocked |
| pwrdn_ok | output | 1 | Power-down request passed on |
| cfg_clk_drive | output | 1 | 1 = configuration clock pin driven, 0 = input |
| cfg_mode | output | 3 | Latched decoded mode (7 = none) |
| cfg_ready | output | 1 | Initialization complete, configuration may begin |
| mode_err | output | 1 | Reserved mode code was captured |

## Verification
The bench counts tick pulses exactly. It looks for ready one tick before the end count and again at the end count, so a counter that is off by one, or that uses the short count for master modes, shows up as a wrong tick total. Mode pins are changed in the middle of a run to a code whose time-out length and clock direction differ from the captured one, so a design that keeps sampling the pins would finish at the wrong count or flip the clock direction. All three reserved codes are fed more ticks than even a master run needs, so a design that falls through to ready would be caught. Power-good is also dropped during the time-out, from ready and from the error state, and ticks are sent while idle, so a design that fails to clear its counter or flags would finish early or stay flagged.

// File: rtl/pwrinit_pkg.sv
package pwrinit_pkg;

  typedef enum logic [2:0] {
    CM_MSER  = 3'd0,
    CM_MBUP  = 3'd1,
    CM_MBDN  = 3'd2,
    CM_PERI  = 3'd3,
    CM_SLAVE = 3'd4,
    CM_NONE  = 3'd7
  } cfg_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_HOLD_ERR,
    ST_READY
  } seq_state_e;

  // R1: pin code to mode
  function automatic cfg_mode_e decode_sel(input logic [2:0] sel);
    cfg_mode_e m;
    case (sel)
      3'b000:  m = CM_MSER;
      3'b001:  m = CM_MBUP;
      3'b011:  m = CM_MBDN;
      3'b101:  m = CM_PERI;
      3'b111:  m = CM_SLAVE;
      default: m = CM_NONE;
    endcase
    return m;
  endfunction

  function automatic logic mode_is_master(input cfg_mode_e m);
    return (m == CM_MSER) || (m == CM_MBUP) || (m == CM_MBDN);
  endfunction

  function automatic logic mode_drives_clk(input cfg_mode_e m);
    return mode_is_master(m) || (m == CM_PERI);
  endfunction

endpackage

// File: rtl/pi_mode_latch.sv
module pi_mode_latch
  import pwrinit_pkg::*;
(
  input  logic      clk,
  input  logic      pwr_good,
  input  logic      capture,
  input  logic [2:0] sel,
  output cfg_mode_e mode_q,
  output logic      is_master,
  output logic      clk_drive,
  output logic      no_mode
);

  always_ff @(posedge clk) begin
    if (!pwr_good)
      mode_q <= CM_NONE;
    else if (capture)
      mode_q <= decode_sel(sel);
  end

  assign is_master = mode_is_master(mode_q);
  assign clk_drive = mode_drives_clk(mode_q);
  assign no_mode   = (mode_q == CM_NONE);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !capture |=> $stable(mode_q));

endmodule

// File: rtl/pi_timeout.sv
module pi_timeout #(
  parameter int BASE_TICKS = 16384
) (
  input  logic clk,
  input  logic run,
  input  logic tick,
  input  logic long_sel,
  output logic done
);

  localparam int LONG_TICKS = 4 * BASE_TICKS;
  localparam int CW         = $clog2(LONG_TICKS + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = long_sel ? CW'(LONG_TICKS) : CW'(BASE_TICKS);

  always_ff @(posedge clk) begin
    if (!run)
      cnt <= '0;
    else if (tick)
      cnt <= cnt + 1'b1;
  end

  assign done = run && tick && (cnt == lim - 1'b1);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!run)
    cnt < lim);

endmodule

// File: rtl/pi_seq_fsm.sv
module pi_seq_fsm
  import pwrinit_pkg::*;
(
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       tmo_done,
  input  logic       no_mode,
  output seq_state_e state,
  output logic       run_tmo,
  output logic       capture
);

  seq_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:     nxt = ST_INIT;
      ST_INIT: begin
        if (no_mode)       nxt = ST_HOLD_ERR;
        else if (tmo_done) nxt = ST_READY;
      end
      ST_HOLD_ERR: nxt = ST_HOLD_ERR;
      ST_READY:    nxt = ST_READY;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!pwr_good)
      state <= ST_IDLE;
    else
      state <= nxt;
  end

  assign run_tmo = (state == ST_INIT) && !no_mode;
  assign capture = (state == ST_IDLE) && pwr_good;

  // R3
  no_early_ready_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == ST_INIT && !tmo_done) |=> (state != ST_READY));

  // R8
  err_reserved_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == ST_HOLD_ERR) |-> no_mode);

  logic pg_low_q;
  always_ff @(posedge clk) pg_low_q <= !pwr_good;

  // R9
  always_ff @(posedge clk) begin
    if (pg_low_q === 1'b1)
      idle_after_drop_chk: assert (state == ST_IDLE);
  end

endmodule

// File: rtl/poweron_init_seq.sv
module poweron_init_seq
  import pwrinit_pkg::*;
#(
  parameter int BASE_TICKS = 16384
) (
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       tick,
  input  logic [2:0] cfg_sel,
  input  logic       pwrdn_req,
  output logic       io_hiz,
  output logic       io_pullup_en,
  output logic       pwrdn_inhibit,
  output logic       pwrdn_ok,
  output logic       cfg_clk_drive,
  output logic [2:0] cfg_mode,
  output logic       cfg_ready,
  output logic       mode_err
);

  seq_state_e state;
  cfg_mode_e  mode_q;
  logic       run_tmo, capture, tmo_done;
  logic       is_master, clk_drive, no_mode;
  logic       in_init;

  pi_seq_fsm u_fsm (
    .clk      (clk),
    .pwr_good (pwr_good),
    .tmo_done (tmo_done),
    .no_mode  (no_mode),
    .state    (state),
    .run_tmo  (run_tmo),
    .capture  (capture)
  );

  pi_mode_latch u_latch (
    .clk       (clk),
    .pwr_good  (pwr_good),
    .capture   (capture),
    .sel       (cfg_sel),
    .mode_q    (mode_q),
    .is_master (is_master),
    .clk_drive (clk_drive),
    .no_mode   (no_mode)
  );

  pi_timeout #(.BASE_TICKS(BASE_TICKS)) u_tmo (
    .clk      (clk),
    .run      (run_tmo),
    .tick     (tick),
    .long_sel (is_master),
    .done     (tmo_done)
  );

  assign in_init       = (state == ST_INIT) || (state == ST_HOLD_ERR);
  assign io_hiz        = (state != ST_READY);
  assign io_pullup_en  = in_init;
  assign pwrdn_inhibit = in_init;
  assign pwrdn_ok      = pwrdn_req && !in_init;
  assign cfg_clk_drive = clk_drive;
  assign cfg_mode      = mode_q;
  assign cfg_ready     = (state == ST_READY);
  assign mode_err      = (state == ST_HOLD_ERR);

  // R6
  clk_dir_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    cfg_ready |-> (cfg_clk_drive == (cfg_mode != 3'd4)));

endmodule

// File: tb/poweron_init_seq_tb_top.sv
`timescale 1ns/1ps
module poweron_init_seq_tb_top;

  localparam int B = 8;

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] cfg_sel = 3'b000;
  logic       pwrdn_req = 1'b0;
  logic       io_hiz, io_pullup_en, pwrdn_inhibit, pwrdn_ok;
  logic       cfg_clk_drive, cfg_ready, mode_err;
  logic [2:0] cfg_mode;

  always #10 clk = ~clk;

  poweron_init_seq #(.BASE_TICKS(B)) dut_i (
    .clk(clk), .pwr_good(pwr_good), .tick(tick), .cfg_sel(cfg_sel),
    .pwrdn_req(pwrdn_req), .io_hiz(io_hiz), .io_pullup_en(io_pullup_en),
    .pwrdn_inhibit(pwrdn_inhibit), .pwrdn_ok(pwrdn_ok),
    .cfg_clk_drive(cfg_clk_drive), .cfg_mode(cfg_mode),
    .cfg_ready(cfg_ready), .mode_err(mode_err)
  );

  int errors = 0;
  int checks = 0;

  typedef struct {
    int    mode;
    int    ticks;
    int    clkdrv;
    int    err;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: independent tick count since power-good rose
  int   tcount = 0;
  logic rdy_d = 1'b0;
  logic err_d = 1'b0;

  always @(posedge clk) begin
    if (!pwr_good) tcount <= 0;
    else if (tick) tcount <= tcount + 1;
  end

  always @(negedge clk) begin
    if ((cfg_ready && !rdy_d) || (mode_err && !err_d)) begin : pop_blk
      exp_t e;
      if (sb_q.size() == 0) begin
        chk("R1", "unexpected completion", 1, 0);
      end else begin
        e = sb_q.pop_front();
        if (e.err == 0) chk(e.tag, "ticks to ready", tcount, e.ticks);
        chk("R1", "latched mode", int'(cfg_mode), e.mode);
        chk("R6", "clock pin drive", int'(cfg_clk_drive), e.clkdrv);
        chk("R8", "error flag", int'(mode_err), e.err);
      end
    end
    rdy_d <= cfg_ready;
    err_d <= mode_err;
  end

  task automatic pulse(int gap);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic idle_check();
    pwr_good  = 1'b0;
    pwrdn_req = 1'b1;
    @(negedge clk);
    chk("R9", "ready after drop", int'(cfg_ready), 0);
    chk("R9", "error after drop", int'(mode_err), 0);
    chk("R9", "mode after drop", int'(cfg_mode), 7);
    chk("R9", "clk drive after drop", int'(cfg_clk_drive), 0);
    chk("R4", "pull-up idle", int'(io_pullup_en), 0);
    chk("R4", "hiz idle", int'(io_hiz), 1);
    chk("R5", "power-down idle", int'(pwrdn_ok), 1);
    // R10: ticks while idle must not count
    pulse(0); pulse(1); pulse(0);
    pwrdn_req = 1'b0;
  endtask

  task automatic run_case(logic [2:0] sel, int exp_mode, int exp_ticks,
                          int exp_clk, int is_err, int gap,
                          int chg, logic [2:0] chg_sel, string tag);
    exp_t e;
    idle_check();
    cfg_sel = sel;
    e.mode = exp_mode; e.ticks = exp_ticks; e.clkdrv = exp_clk;
    e.err = is_err; e.tag = tag;
    sb_q.push_back(e);
    pwr_good = 1'b1;
    @(negedge clk);
    chk("R4", "hiz during init", int'(io_hiz), 1);
    chk("R4", "pull-up during init", int'(io_pullup_en), 1);
    chk("R5", "inhibit during init", int'(pwrdn_inhibit), 1);
    pwrdn_req = 1'b1;
    #1;
    chk("R5", "request ignored during init", int'(pwrdn_ok), 0);
    if (is_err == 0) begin
      for (int i = 0; i < exp_ticks; i++) begin
        if (i == exp_ticks - 1) chk(tag, "ready one tick early", int'(cfg_ready), 0);
        if (chg != 0 && i == 3) cfg_sel = chg_sel;
        pulse(gap);
      end
      chk(tag, "ready at end count", int'(cfg_ready), 1);
      chk("R4", "hiz released at ready", int'(io_hiz), 0);
      chk("R4", "pull-up off at ready", int'(io_pullup_en), 0);
      chk("R5", "request passed at ready", int'(pwrdn_ok), 1);
      pulse(0); pulse(0);
      chk("R10", "ready held", int'(cfg_ready), 1);
    end else begin
      for (int i = 0; i < 4 * B + 4; i++) pulse(gap);
      chk("R8", "no ready on reserved", int'(cfg_ready), 0);
      chk("R8", "error held", int'(mode_err), 1);
      chk("R8", "pull-up kept", int'(io_pullup_en), 1);
      chk("R8", "power-down still blocked", int'(pwrdn_ok), 0);
    end
    pwrdn_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset ready", int'(cfg_ready), 0);
    chk("R9", "reset error", int'(mode_err), 0);
    chk("R9", "reset mode", int'(cfg_mode), 7);
    // masters: R3 count 4*B
    run_case(3'b000, 0, 4 * B, 1, 0, 0, 0, 3'b000, "R3");
    run_case(3'b001, 1, 4 * B, 1, 0, 2, 0, 3'b000, "R3");
    // R7: pins change to slave mid-run, must still finish as master
    run_case(3'b011, 2, 4 * B, 1, 0, 1, 1, 3'b111, "R3");
    // base modes: R2
    run_case(3'b101, 3, B, 1, 0, 0, 0, 3'b000, "R2");
    // R7: pins change to master mid-run, must still finish at base count
    run_case(3'b111, 4, B, 0, 0, 1, 1, 3'b000, "R2");
    // reserved codes: R8
    run_case(3'b010, 7, 0, 0, 1, 0, 0, 3'b000, "R8");
    run_case(3'b100, 7, 0, 0, 1, 1, 0, 3'b000, "R8");
    run_case(3'b110, 7, 0, 0, 1, 0, 0, 3'b000, "R8");
    // R9: abort in the middle of a master time-out, then a full base run
    idle_check();
    cfg_sel  = 3'b000;
    pwr_good = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) pulse(0);
    run_case(3'b101, 3, B, 1, 0, 0, 0, 3'b000, "R2");
    idle_check();
    chk("R1", "scoreboard drained", sb_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule